// File: doc/BRIEF.md
# Trapping Integer Add/Subtract/Compare Unit

This block is the integer arithmetic slice of a simple load/store processor's execute stage. It computes add, subtract, add-with-immediate, signed set-less-than and unsigned set-less-than on 32-bit register operands. Every operation goes through one shared adder. Subtraction and both comparisons feed the adder the inverted second operand with a carry-in of one. The signed and unsigned comparisons differ only in how they read the adder's flags.

Add, add-immediate and subtract each come in a trapping form and a non-trapping form. When a trapping form overflows under a valid strobe, the block does three things in the same cycle: it withholds the register write, pulses an exception output and shows a fixed redirect address. On the next clock edge it stores the faulting instruction's address so execution can resume there. The non-trapping forms wrap silently. The add-immediate forms sign-extend their 16-bit immediate, and this includes the non-trapping one.

All outputs are combinational from the inputs except the saved-address register. There is no back-pressure. The unit takes one operation in every cycle that `op_valid` is high, and it never stalls.

Top module: `trap_arith_unit`

## Requirements
- R1: Opcode encoding on `op_code` is 0 add (trapping), 1 add (non-trapping), 2 add-immediate (trapping), 3 add-immediate (non-trapping), 4 subtract (trapping), 5 subtract (non-trapping), 6 signed set-less-than, 7 unsigned set-less-than. Both add forms (0 and 1) return `src_a + src_b` modulo 2^32 on `result`.
- R2: Both subtract forms (4 and 5) return `src_a - src_b` modulo 2^32, formed as `src_a` plus the inverted `src_b` plus one.
- R3: Opcodes 2 and 3 add `src_a` to `imm16` sign-extended to 32 bits (bit 15 copied into bits 31..16). Opcode 3 also sign-extends.
- R4: Opcodes 0 and 2 overflow only when both addends share a sign and the sum's sign differs from it. Addends of opposite sign never overflow.
- R5: Opcode 4 overflows only when the operands' signs differ and the difference's sign differs from the sign of `src_a`. Operands of equal sign never overflow.
- R6: Opcodes 1, 3 and 5 never assert `ovf_trap`, even when the signed result wraps.
- R7: Opcode 6 compares as two's complement and never traps. `result` has bits 31..1 at zero and bit 0 equal to (`src_a` < `src_b`), so 0xFFFFFFFF against 1 gives 1.
- R8: Opcode 7 compares as unsigned magnitudes in the same result format, so 0xFFFFFFFF against 1 gives 0.
- R9: `ovf_trap` is high only when `op_valid` is high and a trapping opcode overflows. `reg_we` equals `op_valid` and not `ovf_trap`.
- R10: `epc_q` resets to zero. It loads `inst_addr` on the clock edge that ends a cycle with `ovf_trap` high, and it holds its value on every other edge.
- R11: `trap_target` always equals the parameter `TRAP_VECTOR`, default 0x80000180.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select (see R1) |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand |
| imm16 | input | 16 | Immediate field |
| inst_addr | input | 32 | Address of the current instruction |
| result | output | 32 | Sum, difference or comparison bit |
| reg_we | output | 1 | Register write enable |
| ovf_trap | output | 1 | Overflow exception pulse |
| trap_target | output | 32 | Fixed exception redirect address |
| epc_q | output | 32 | Saved address of the faulting instruction |

## Verification
Assertions check on every cycle that a trap always has a valid strobe and always suppresses the write. They also check that the non-trapping and comparison opcodes never trap, and that opposite-sign adds and equal-sign subtracts never trap. Two more checks cover the comparison result's upper bits, which must stay zero, and the saved address, which must load only on a trap and hold otherwise. Arithmetic values themselves need the bench. Its reference model covers the exact sums, the extremes of the signed range, sign extension of immediates with the top bit set, and the two comparison flavours on the same bit patterns. It also covers a second reset issued after a trap has already loaded the saved address.

// File: rtl/trap_arith_pkg.sv
package trap_arith_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_ADDU  = 3'd1,
    OP_ADDI  = 3'd2,
    OP_ADDIU = 3'd3,
    OP_SUB   = 3'd4,
    OP_SUBU  = 3'd5,
    OP_SLT   = 3'd6,
    OP_SLTU  = 3'd7
  } arith_op_e;

  typedef struct packed {
    logic use_imm;      // second addend comes from the immediate
    logic negate;       // invert second addend, carry in one
    logic may_trap;     // overflow raises an exception
    logic is_cmp;       // result is a single comparison bit
    logic cmp_unsigned; // comparison reads carry instead of sign
  } op_ctrl_t;

  function automatic op_ctrl_t decode_op(arith_op_e op);
    op_ctrl_t c;
    c = '0;
    unique case (op)
      OP_ADD:   c.may_trap = 1'b1;
      OP_ADDU:  c = '0;
      OP_ADDI:  begin c.use_imm = 1'b1; c.may_trap = 1'b1; end
      OP_ADDIU: c.use_imm = 1'b1;
      OP_SUB:   begin c.negate = 1'b1; c.may_trap = 1'b1; end
      OP_SUBU:  c.negate = 1'b1;
      OP_SLT:   begin c.negate = 1'b1; c.is_cmp = 1'b1; end
      OP_SLTU:  begin c.negate = 1'b1; c.is_cmp = 1'b1; c.cmp_unsigned = 1'b1; end
      default:  c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/addend_select.sv
module addend_select #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [W-1:0]     reg_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic             negate,
  output logic [W-1:0]     addend,
  output logic             carry_in
);
  localparam int EXT_W = W - IMM_W;

  logic [W-1:0] imm_ext;
  logic [W-1:0] raw_b;

  // replicate the immediate's top bit into the upper field
  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_noext
      assign imm_ext = imm[W-1:0];
    end
  endgenerate

  always_comb begin
    raw_b    = use_imm ? imm_ext : reg_b;
    addend   = negate ? ~raw_b : raw_b;
    carry_in = negate;
  end
endmodule

// File: rtl/shared_adder.sv
module shared_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] carry;

  assign carry[0] = cin;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum[i]     = a[i] ^ b[i] ^ carry[i];
      assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
    end
  endgenerate

  assign cout = carry[W];
endmodule

// File: rtl/flag_eval.sv
module flag_eval (
  input  logic a_msb,
  input  logic b_msb,     // sign of the addend actually fed to the adder
  input  logic sum_msb,
  input  logic cout,
  input  logic cmp_unsigned,
  output logic ovf_raw,
  output logic less
);
  logic lt_signed;
  logic lt_unsigned;

  always_comb begin
    ovf_raw     = (a_msb == b_msb) && (sum_msb != a_msb);
    lt_signed   = sum_msb ^ ovf_raw;
    lt_unsigned = ~cout;
    less        = cmp_unsigned ? lt_unsigned : lt_signed;
  end
endmodule

// File: rtl/trap_arith_unit.sv
module trap_arith_unit
  import trap_arith_pkg::*;
#(
  parameter int          W           = 32,
  parameter int          IMM_W       = 16,
  parameter logic [W-1:0] TRAP_VECTOR = 32'h8000_0180
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [2:0]       op_code,
  input  logic [W-1:0]     src_a,
  input  logic [W-1:0]     src_b,
  input  logic [IMM_W-1:0] imm16,
  input  logic [W-1:0]     inst_addr,
  output logic [W-1:0]     result,
  output logic             reg_we,
  output logic             ovf_trap,
  output logic [W-1:0]     trap_target,
  output logic [W-1:0]     epc_q
);
  localparam int MSB = W - 1;

  arith_op_e    op;
  op_ctrl_t     ctrl;
  logic [W-1:0] addend;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout;
  logic         ovf_raw;
  logic         less;

  assign op   = arith_op_e'(op_code);
  assign ctrl = decode_op(op);

  addend_select #(.W(W), .IMM_W(IMM_W)) u_sel (
    .reg_b    (src_b),
    .imm      (imm16),
    .use_imm  (ctrl.use_imm),
    .negate   (ctrl.negate),
    .addend   (addend),
    .carry_in (cin)
  );

  shared_adder #(.W(W)) u_add (
    .a    (src_a),
    .b    (addend),
    .cin  (cin),
    .sum  (sum),
    .cout (cout)
  );

  flag_eval u_flags (
    .a_msb        (src_a[MSB]),
    .b_msb        (addend[MSB]),
    .sum_msb      (sum[MSB]),
    .cout         (cout),
    .cmp_unsigned (ctrl.cmp_unsigned),
    .ovf_raw      (ovf_raw),
    .less         (less)
  );

  always_comb begin
    result      = ctrl.is_cmp ? {{(W-1){1'b0}}, less} : sum;
    ovf_trap    = op_valid & ctrl.may_trap & ovf_raw;
    reg_we      = op_valid & ~ovf_trap;
    trap_target = TRAP_VECTOR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        epc_q <= '0;
    else if (ovf_trap) epc_q <= inst_addr;
  end

  // R9: exception only under a valid strobe, and never with a write
  assert_trap_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> op_valid);
  assert_no_write_on_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> !reg_we);
  // R6: non-trapping arithmetic forms stay silent
  assert_quiet_unsigned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_ADDU || op == OP_ADDIU || op == OP_SUBU)) |-> !ovf_trap);
  // R7: comparisons never trap and clear the upper bits
  assert_cmp_no_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op == OP_SLT || op == OP_SLTU)) |-> !ovf_trap);
  assert_cmp_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SLT || op == OP_SLTU) |-> (result[W-1:1] == '0));
  // R4: opposite-sign addition cannot overflow
  assert_add_mixed_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD && src_a[MSB] != src_b[MSB]) |-> !ovf_trap);
  // R5: equal-sign subtraction cannot overflow
  assert_sub_same_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUB && src_a[MSB] == src_b[MSB]) |-> !ovf_trap);
  // R10: saved address loads on a trap, holds otherwise
  assert_epc_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |=> (epc_q == $past(inst_addr)));
  assert_epc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_trap |=> $stable(epc_q));
endmodule

// File: tb/test_trap_arith_unit.sv
module test_trap_arith_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  MAX_CYCLES = 200000;
  localparam logic [31:0] VEC = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [31:0] src_a = '0, src_b = '0, inst_addr = '0;
  logic [15:0] imm16 = '0;
  logic [31:0] result, trap_target, epc_q;
  logic        reg_we, ovf_trap;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [31:0] model_epc = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trap_arith_unit i_trap_arith_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .imm16(imm16), .inst_addr(inst_addr),
    .result(result), .reg_we(reg_we), .ovf_trap(ovf_trap),
    .trap_target(trap_target), .epc_q(epc_q)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference: integer arithmetic, no adder structure
  task automatic apply(bit v, int op, logic [31:0] a, logic [31:0] b,
                       logic [15:0] imm, logic [31:0] pc);
    longint sa, sb, full;
    logic [31:0] exp_res;
    bit ovf, trap, trapping;
    string rq_res, rq_trap;
    @(negedge clk);
    op_valid = v; op_code = op[2:0]; src_a = a; src_b = b; imm16 = imm; inst_addr = pc;
    sa = longint'($signed(a));
    sb = (op == 2 || op == 3) ? longint'($signed(imm)) : longint'($signed(b));
    ovf = 1'b0; trapping = 1'b0; exp_res = '0;
    case (op)
      0, 1, 2, 3: begin
        full = sa + sb; exp_res = full[31:0];
        ovf = (full > 64'sd2147483647) || (full < -64'sd2147483648);
        trapping = (op == 0 || op == 2);
        rq_res = (op < 2) ? "R1" : "R3";
      end
      4, 5: begin
        full = sa - sb; exp_res = full[31:0];
        ovf = (full > 64'sd2147483647) || (full < -64'sd2147483648);
        trapping = (op == 4);
        rq_res = "R2";
      end
      6: begin exp_res = {31'b0, ($signed(a) < $signed(b))}; rq_res = "R7"; end
      default: begin exp_res = {31'b0, (a < b)}; rq_res = "R8"; end
    endcase
    trap = v && trapping && ovf;
    if (!v)                rq_trap = "R9";
    else if (op == 0 || op == 2) rq_trap = "R4";
    else if (op == 4)      rq_trap = "R5";
    else if (op >= 6)      rq_trap = "R7";
    else                   rq_trap = "R6";
    #1;
    check(rq_res, "result", result, exp_res);
    check(rq_trap, "ovf_trap", {31'b0, ovf_trap}, {31'b0, trap});
    check("R9", "reg_we", {31'b0, reg_we}, {31'b0, v && !trap});
    check("R11", "trap_target", trap_target, VEC);
    check("R10", "epc_q before edge", epc_q, model_epc);
    @(posedge clk);
    if (trap) model_epc = pc;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10", "epc_q in reset", epc_q, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1 / R4: add, positive wrap traps only in trapping form
    apply(1, 0, 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h0000_1000);
    apply(1, 1, 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h0000_1004);
    apply(1, 0, 32'h8000_0000, 32'h8000_0000, 16'h0, 32'h0000_1008);
    apply(1, 0, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'h0, 32'h0000_100C);
    apply(1, 0, 32'h1234_5678, 32'h1111_1111, 16'h0, 32'h0000_1010);
    // R3: immediates with top bit set, both forms
    apply(1, 2, 32'h0, 32'h0, 16'h8000, 32'h0000_1014);
    apply(1, 3, 32'h0, 32'h0, 16'hFFFF, 32'h0000_1018);
    apply(1, 2, 32'h8000_0000, 32'h0, 16'hFFFF, 32'h0000_101C);
    apply(1, 3, 32'h8000_0000, 32'h0, 16'hFFFF, 32'h0000_1020);
    // R2 / R5 / R6: subtract extremes
    apply(1, 4, 32'h8000_0000, 32'h1, 16'h0, 32'h0000_1024);
    apply(1, 4, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 32'h0000_1028);
    apply(1, 5, 32'h8000_0000, 32'h1, 16'h0, 32'h0000_102C);
    apply(1, 4, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 16'h0, 32'h0000_1030);
    apply(1, 4, 32'h0000_0005, 32'h0000_0009, 16'h0, 32'h0000_1034);
    // R7 / R8: same bit patterns, both comparisons
    apply(1, 6, 32'hFFFF_FFFF, 32'h1, 16'h0, 32'h0000_1038);
    apply(1, 7, 32'hFFFF_FFFF, 32'h1, 16'h0, 32'h0000_103C);
    apply(1, 6, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 32'h0000_1040);
    apply(1, 7, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 32'h0000_1044);
    apply(1, 6, 32'h5, 32'h5, 16'h0, 32'h0000_1048);
    // R9: overflowing operands without valid strobe
    apply(0, 0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h0, 32'hDEAD_0000);
    apply(0, 4, 32'h8000_0000, 32'h1, 16'h0, 32'hDEAD_0004);

    // R10: second reset after epc has been loaded
    @(negedge clk); rst_n = 1'b0; model_epc = '0;
    #1;
    check("R10", "epc_q after second reset", epc_q, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom(); rb = $urandom();
      if (i % 4 == 0) begin ra[31:28] = 4'h7; rb[31:28] = 4'h7; end
      if (i % 4 == 1) begin ra[31:28] = 4'h8; rb[31:28] = 4'h7; end
      apply((i % 9) != 0, i % 8, ra, rb, 16'($urandom()), 32'($urandom()));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule